// File: doc/BRIEF.md
# Lookahead Carry Adder

This block adds two unsigned operands of parameterised width and a one-bit carry input. It returns a sum of the same width and a carry output. The design is purely combinational. Every internal carry is computed straight from per-bit carry-generate and carry-propagate terms and the carry input, so no carry has to wait for the stage beside it. Because of this, the logic depth of each carry does not grow one stage at a time with the width.

Each bit first forms a generate flag (both operand bits are set) and a propagate flag (at least one operand bit is set). The carry into position k is the OR of k+1 product terms. Each term is one generate flag, or the carry input, ANDed with every propagate flag between that point and k. The sum bits are then the XOR of the operand bits with their lookahead carry. The block can be placed anywhere a fast unsigned add is needed. It has no clock, no reset and no state.

Top module: `cla_adder`

## Requirements
- R1: For every bit i, the generate flag is a[i] AND b[i] and the propagate flag is a[i] OR b[i]. A bit whose generate flag is set produces a carry into bit i+1 whatever its incoming carry is. A bit with only its propagate flag set passes its incoming carry on.
- R2: The carry into position k (1 <= k <= WIDTH, with position WIDTH being cout) is the OR of k+1 products. Each product is either cin ANDed with propagate flags 0..k-1, or the generate flag j ANDed with propagate flags j+1..k-1. No carry is taken from the output of a neighbouring stage.
- R3: The carries obey the recurrence: the carry into bit i+1 equals generate[i] OR (propagate[i] AND carry into bit i), and the carry into bit 0 is cin.
- R4: cout is 1 exactly when the true sum a+b+cin is at least 2^WIDTH. With no generate flag set and cin low, cout is 0.
- R5: Sum bit i equals a[i] XOR b[i] XOR the carry into bit i. In particular, sum[0] = a[0] XOR b[0] XOR cin.
- R6: For every combination of a, b and cin, {cout, sum} equals a + b + cin taken as a WIDTH+1 bit unsigned value.
- R7: The outputs follow input changes with no clock edge involved. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a+b+cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
Whenever the inputs settle, the embedded immediate assertions check several properties. Generate never appears without propagate. Each lookahead carry agrees with the stage-by-stage recurrence. cout stays low when nothing generates and cin is low. The sum bit 0 and the full result match an ordinary addition. Two things only the bench scenarios can show. The first is that the result is right for every one of the operand and carry-input patterns. The second is that generate and propagate behave as R1 describes at particular bit positions, seen only through sum and cout. The bench also shows that the outputs move between clock edges, with no edge needed.

// File: rtl/cla_pkg.sv
// Package: cla_pkg
// Shared helpers for the lookahead adder. Assumes operand widths of at most
// SPAN_MAX bits.
package cla_pkg;
    localparam int SPAN_MAX = 64;

    // AND of v[lo] .. v[hi-1]; an empty range yields 1.
    function automatic logic span_and(input logic [SPAN_MAX-1:0] v,
                                      input int lo, input int hi);
        logic r;
        r = 1'b1;
        for (int i = 0; i < SPAN_MAX; i++) begin
            if (i >= lo && i < hi) r = r & v[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/cla_gp_gen.sv
// Module: cla_gp_gen
// Forms the per-bit generate and propagate flags from the two operands.
// Assumes nothing beyond matching operand widths.
module cla_gp_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    // One generate and one propagate flag for each bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] | b[i];
    end

    // Generate may only ever appear where propagate is also set (R1).
    always_comb begin
        a_r1_gen_implies_prop: assert ((gen & ~prop) == '0)
            else $error("R1: generate set without propagate");
    end
endmodule

// File: rtl/cla_carry_net.sv
// Module: cla_carry_net
// Produces every carry as a flat sum of products of generate/propagate flags
// and the carry input. carry[0] is cin and carry[WIDTH] is the carry out.
// Assumes WIDTH <= cla_pkg::SPAN_MAX.
module cla_carry_net #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] prop,
    input  logic             cin,
    output logic [WIDTH:0]   carry
);
    localparam int SPAN = cla_pkg::SPAN_MAX;

    logic [SPAN-1:0] prop_ext;
    assign prop_ext = SPAN'(prop);
    assign carry[0] = cin;

    // One flat OR of k+1 product terms for each carry position k.
    for (genvar k = 1; k <= WIDTH; k++) begin : g_carry
        logic term_or;
        // Combine the cin term with the generate terms of bits 0..k-1.
        always_comb begin
            term_or = cin & cla_pkg::span_and(prop_ext, 0, k);
            for (int j = 0; j < k; j++) begin
                term_or = term_or | (gen[j] & cla_pkg::span_and(prop_ext, j + 1, k));
            end
        end
        assign carry[k] = term_or;
    end

    // Cross-check the flat carries against the stage recurrence (R3) and the
    // blocked-carry case (R4).
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            a_r3_recurrence: assert (carry[k+1] == (gen[k] | (prop[k] & carry[k])))
                else $error("R3: carry %0d breaks recurrence", k + 1);
        end
        if (gen == '0 && !cin) begin
            a_r4_no_source: assert (carry[WIDTH] == 1'b0)
                else $error("R4: carry out without any source");
        end
    end
endmodule

// File: rtl/cla_sum_xor.sv
// Module: cla_sum_xor
// Forms each sum bit from its operand bits and the lookahead carry into it.
// Assumes the carries are already resolved.
module cla_sum_xor #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] carry_in,
    output logic [WIDTH-1:0] sum
);
    // One three-input XOR for each sum bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = a[i] ^ b[i] ^ carry_in[i];
    end
endmodule

// File: rtl/cla_adder.sv
// Module: cla_adder
// Combinational unsigned lookahead adder: sum/cout = a + b + cin.
// No clock or state; assumes WIDTH <= cla_pkg::SPAN_MAX.
module cla_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH:0]   carry;

    cla_gp_gen #(.WIDTH(WIDTH)) u_gp (
        .a(a), .b(b), .gen(gen), .prop(prop)
    );

    cla_carry_net #(.WIDTH(WIDTH)) u_carry (
        .gen(gen), .prop(prop), .cin(cin), .carry(carry)
    );

    cla_sum_xor #(.WIDTH(WIDTH)) u_sum (
        .a(a), .b(b), .carry_in(carry[WIDTH-1:0]), .sum(sum)
    );

    // Carry out of the top bit.
    assign cout = carry[WIDTH];

    // The port-level result must match a plain addition (R5, R6).
    always_comb begin
        a_r5_low_bit: assert (sum[0] == (a[0] ^ b[0] ^ cin))
            else $error("R5: sum bit 0 wrong");
        a_r6_total: assert ({cout, sum} ==
                            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("R6: result differs from a+b+cin");
    end
endmodule

// File: tb/cla_adder_tb.sv
// Bench for cla_adder: exhaustive comparison with a behavioural add plus
// directed generate/propagate and no-clock cases.
module cla_adder_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cla_adder #(.WIDTH(W)) u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a rising edge, compare at the following falling edge.
    task automatic apply(input int va, input int vb, input int vc);
        @(posedge clk);
        a = W'(va); b = W'(vb); cin = vc[0];
        @(negedge clk);
    endtask

    initial begin
        // Idle state: all-zero inputs give all-zero outputs (R6).
        @(negedge clk);
        check("R6 idle", {27'd0, cout, sum}, 0);

        // Exhaustive sweep against an integer model.
        for (int v = 0; v < (1 << (2 * W + 1)); v++) begin
            int va, vb, vc, tot;
            va = v & ((1 << W) - 1);
            vb = (v >> W) & ((1 << W) - 1);
            vc = (v >> (2 * W)) & 1;
            tot = va + vb + vc;
            apply(va, vb, vc);
            check("R6 total", {27'd0, cout, sum}, tot);
            check("R4 cout", int'(cout), tot >> W);
            check("R5 bit0", int'(sum[0]), (va ^ vb ^ vc) & 1);
            // R3 and R2: recover each carry from the ports and test the recurrence.
            for (int i = 0; i < W - 1; i++) begin
                int ci, cn, g, p;
                ci = ((int'(sum) ^ va ^ vb) >> i) & 1;
                cn = ((int'(sum) ^ va ^ vb) >> (i + 1)) & 1;
                g  = ((va & vb) >> i) & 1;
                p  = ((va | vb) >> i) & 1;
                check("R3 recurrence", cn, g | (p & ci));
            end
            check("R2 carry out", int'(cout), ((va + vb + vc) >> W) & 1);
        end

        // R1: a generate at bit 1 with cin high still sets bit 2.
        apply(4'b0010, 4'b0010, 1);
        check("R1 generate", int'(sum), 4'b0101);
        // R1: propagates on bits 0..3 pass cin all the way to cout.
        apply(4'b1111, 4'b0000, 1);
        check("R1 propagate", {27'd0, cout, sum}, 5'b10000);
        // R4: no generate and cin low keeps cout low.
        apply(4'b1010, 4'b0101, 0);
        check("R4 blocked", int'(cout), 0);

        // R7: change inputs between edges and look 1 ns later.
        @(negedge clk);
        #1 a = 4'd9; b = 4'd8; cin = 1'b0;
        #1 check("R7 no clock", {27'd0, cout, sum}, 17);
        #1 a = 4'd3;
        #1 check("R7 follows", {27'd0, cout, sum}, 11);

        done = 1'b1;
    end

    // End the run, either normally or when the watchdog expires.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule